// File: doc/BRIEF.md
# Per-Switch Overcurrent Gate Guard

This block sits between a motor-control PWM source and the gate drivers of a three-phase inverter bridge with one extra brake-chopper switch. Each switch has an active-low on-command and two comparator flags from the analog current sensing. The first flag is a short-circuit trip and the second is an overload warning. The block turns each command into a registered gate enable.

A short-circuit flag removes the gate of the one switch that raised it and sets a shared fault output. The other switches keep running. The trip clears by itself when that switch's command starts its next on-pulse, so the controller never has to issue a global reset. Overload warnings work the same way on a separate warning output. The brake switch never loses its gate to a trip.

Width rules shape every inverter gate pulse. An on-command that lasts too long is cut short, and the gate stays off until the command is released. Upper switches also have a minimum on-width. Depending on a parameter, an upper pulse shorter than that minimum is either dropped or stretched to the minimum.

Top module: `ocp_pulse_guard`

## Requirements
- R1: A short-circuit flag (`sc_trip[i]` high at a clock edge) on an inverter channel (index below 2*N_LEGS) forces `gate_on[i]` low from the next clock edge. The gates of other channels are not affected.
- R2: Any short-circuit flag, including one on the brake channel, raises `fault` at the next clock edge. `fault` is the OR of all channels that are tripped and not yet cleared.
- R3: A channel's short-circuit trip clears at the first clock where its synchronized command goes from off to on. If the flag is still high in that same clock, the trip stays set.
- R4: The brake channel (index 2*N_LEGS) gate follows its synchronized command. Trips and width limits do not affect it.
- R5: `cl_trip[i]` high raises `warn` at the next edge. The warning for channel i is held until that channel's next synchronized off-to-on transition. The same-clock rule of R3 applies.
- R6: An inverter channel's gate is high for at most MAX_ON_CYC consecutive clocks of one command pulse. After that it stays low until the command goes off.
- R7: With STRETCH_SHORT=0, an upper channel (index below N_LEGS) turns on only once its synchronized command has been on for MIN_ON_CYC clocks. Shorter pulses produce no gate pulse.
- R8: With STRETCH_SHORT=1, each upper-channel on-pulse keeps the gate high for at least MIN_ON_CYC clocks from its start, unless a trip or the width limit cuts it.
- R9: Commands are active low (0 = on). They pass through SYNC_STAGES flops, so a lower or brake gate follows a command change SYNC_STAGES+1 edges later. Channel order is upper legs, then lower legs, then brake.
- R10: While reset is asserted and afterwards until a command arrives, every gate is off and `fault` and `warn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_n | input | 2*N_LEGS+1 | Active-low on-commands, one per switch |
| sc_trip | input | 2*N_LEGS+1 | Short-circuit comparator flags |
| cl_trip | input | 2*N_LEGS+1 | Overload warning comparator flags |
| gate_on | output | 2*N_LEGS+1 | Registered gate enables |
| fault | output | 1 | Short-circuit fault indication |
| warn | output | 1 | Overload warning indication |

## Verification
The bench builds two copies side by side. Both use MIN_ON_CYC=3 and MAX_ON_CYC=12, and they differ only in STRETCH_SHORT, so the suppress and stretch treatments of short upper pulses are seen on the same stimulus. These short limits let directed pulses of 2, 3, 5 and 20 clocks land exactly on the minimum and truncation boundaries in a few cycles. A long random phase then mixes commands and flags across all seven channels, including flags that coincide with a new pulse.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

   typedef enum logic [1:0] {
      CH_UPPER = 2'd0,
      CH_LOWER = 2'd1,
      CH_BRAKE = 2'd2
   } ocp_kind_e;

   function automatic ocp_kind_e ocp_kind_of(input int idx, input int legs);
      if (idx < legs)           return CH_UPPER;
      else if (idx < 2 * legs)  return CH_LOWER;
      else                      return CH_BRAKE;
   endfunction

endpackage

// File: rtl/ocp_cmd_sync.sv
module ocp_cmd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_n_i,
   output logic on_o,
   output logic rise_o
);
   logic [STAGES-1:0] sr_q;
   logic              on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '1;
         on_q <= 1'b0;
      end else begin
         sr_q <= {sr_q[STAGES-2:0], cmd_n_i};
         on_q <= on_o;
      end
   end

   assign on_o   = ~sr_q[STAGES-1];
   assign rise_o = on_o & ~on_q;
endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic nxt_o
);
   logic lat_q;

   assign nxt_o = set_i | (lat_q & ~clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= 1'b0;
      else        lat_q <= nxt_o;
   end
endmodule

// File: rtl/ocp_width_guard.sv
module ocp_width_guard
   import ocp_pkg::*;
#(
   parameter ocp_kind_e   KIND          = CH_LOWER,
   parameter int unsigned MAX_ON_CYC    = 25000,
   parameter int unsigned MIN_ON_CYC    = 100,
   parameter bit          STRETCH_SHORT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_i,
   input  logic rise_i,
   output logic drive_o
);
   localparam int unsigned CW = $clog2(MAX_ON_CYC + 2);

   if (MIN_ON_CYC < 1) begin : g_bad_min
      $error("MIN_ON_CYC must be at least 1");
   end

   if (KIND == CH_BRAKE) begin : g_brake
      logic brake_unused;
      assign brake_unused = clk ^ rst_n ^ rise_i;
      assign drive_o = on_i;
   end else begin : g_arm
      localparam logic [CW-1:0] CAP_V = CW'(MAX_ON_CYC + 1);
      localparam logic [CW-1:0] LIM_V = CW'(MAX_ON_CYC);
      localparam logic [CW-1:0] MIN_V = CW'(MIN_ON_CYC);
      logic [CW-1:0] run_q, run_nx;
      logic          trunc;

      always_comb begin
         if (!on_i)               run_nx = '0;
         else if (rise_i)         run_nx = CW'(1);
         else if (run_q == CAP_V) run_nx = CAP_V;
         else                     run_nx = run_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) run_q <= '0;
         else        run_q <= run_nx;
      end

      assign trunc = on_i && (run_nx > LIM_V);

      if (KIND == CH_UPPER && STRETCH_SHORT) begin : g_stretch
         localparam int unsigned HW = $clog2(MIN_ON_CYC + 1);
         logic [HW-1:0] hold_q;
         logic          min_unused;
         assign min_unused = |MIN_V;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              hold_q <= '0;
            else if (rise_i)         hold_q <= HW'(MIN_ON_CYC - 1);
            else if (hold_q != '0)   hold_q <= hold_q - HW'(1);
         end
         assign drive_o = (on_i || (hold_q != '0)) && !trunc;
      end else if (KIND == CH_UPPER) begin : g_suppress
         assign drive_o = on_i && (run_nx >= MIN_V) && !trunc;
      end else begin : g_lower
         logic min_unused;
         assign min_unused = |MIN_V;
         assign drive_o = on_i && !trunc;
      end
   end
endmodule

// File: rtl/ocp_pulse_guard.sv
module ocp_pulse_guard
   import ocp_pkg::*;
#(
   parameter int unsigned N_LEGS        = 3,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned MAX_ON_CYC    = 25000,
   parameter int unsigned MIN_ON_CYC    = 100,
   parameter bit          STRETCH_SHORT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2*N_LEGS:0] cmd_n,
   input  logic [2*N_LEGS:0] sc_trip,
   input  logic [2*N_LEGS:0] cl_trip,
   output logic [2*N_LEGS:0] gate_on,
   output logic              fault,
   output logic              warn
);
   localparam int unsigned N_CH = 2 * N_LEGS + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MAX_ON_CYC <= MIN_ON_CYC) begin : g_bad_width
      $error("MAX_ON_CYC must exceed MIN_ON_CYC");
   end
   if (N_LEGS < 1) begin : g_bad_legs
      $error("N_LEGS must be at least 1");
   end

   logic [N_CH-1:0] on_s, rise_s, drive, sc_nx, cl_nx, block;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      ocp_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .cmd_n_i(cmd_n[i]),
         .on_o(on_s[i]), .rise_o(rise_s[i])
      );

      ocp_width_guard #(
         .KIND(ocp_kind_of(i, N_LEGS)),
         .MAX_ON_CYC(MAX_ON_CYC),
         .MIN_ON_CYC(MIN_ON_CYC),
         .STRETCH_SHORT(STRETCH_SHORT)
      ) u_width (
         .clk(clk), .rst_n(rst_n), .on_i(on_s[i]), .rise_i(rise_s[i]),
         .drive_o(drive[i])
      );

      ocp_trip_latch u_sc (
         .clk(clk), .rst_n(rst_n), .set_i(sc_trip[i]), .clr_i(rise_s[i]),
         .nxt_o(sc_nx[i])
      );

      ocp_trip_latch u_cl (
         .clk(clk), .rst_n(rst_n), .set_i(cl_trip[i]), .clr_i(rise_s[i]),
         .nxt_o(cl_nx[i])
      );

      if (ocp_kind_of(i, N_LEGS) == CH_BRAKE) begin : g_nobl
         assign block[i] = 1'b0;
      end else begin : g_bl
         assign block[i] = sc_nx[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_on <= '0;
         fault   <= 1'b0;
         warn    <= 1'b0;
      end else begin
         gate_on <= drive & ~block;
         fault   <= |sc_nx;
         warn    <= |cl_nx;
      end
   end
endmodule

// File: rtl/ocp_pulse_guard_chk.sv
module ocp_pulse_guard_chk #(
   parameter int unsigned N_LEGS     = 3,
   parameter int unsigned MAX_ON_CYC = 25000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2*N_LEGS:0] sc_trip,
   input logic [2*N_LEGS:0] cl_trip,
   input logic [2*N_LEGS:0] gate_on,
   input logic              fault,
   input logic              warn
);
   localparam int unsigned W = $clog2(MAX_ON_CYC + 1);

   for (genvar c = 0; c < 2 * N_LEGS; c++) begin : g_sc
      p_sc_gate_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
         sc_trip[c] |=> !gate_on[c]);
   end

   p_fault_on_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|sc_trip) |=> fault);

   p_warn_on_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|cl_trip) |=> warn);

   for (genvar c = N_LEGS; c < 2 * N_LEGS; c++) begin : g_len
      logic [W-1:0] len_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         len_q <= '0;
         else if (!gate_on[c])               len_q <= '0;
         else if (len_q != W'(MAX_ON_CYC))   len_q <= len_q + W'(1);
      end
      p_max_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
         gate_on[c] |-> (len_q < W'(MAX_ON_CYC)));
   end
endmodule

bind ocp_pulse_guard ocp_pulse_guard_chk #(
   .N_LEGS(N_LEGS), .MAX_ON_CYC(MAX_ON_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sc_trip(sc_trip), .cl_trip(cl_trip),
   .gate_on(gate_on), .fault(fault), .warn(warn)
);

// File: tb/ocp_pulse_guard_test.sv
module ocp_pulse_guard_test;
   localparam int LEGS = 3;
   localparam int NCH  = 7;
   localparam int MINC = 3;
   localparam int MAXC = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] cmd_n = '1, sc = '0, cl = '0;
   logic [NCH-1:0] g0, g1;
   logic f0, f1, w0, w1;
   int compared = 0, mismatched = 0;
   string cur_req = "R10";

   always #10 clk = ~clk;

   ocp_pulse_guard #(.N_LEGS(LEGS), .SYNC_STAGES(2), .MAX_ON_CYC(MAXC),
      .MIN_ON_CYC(MINC), .STRETCH_SHORT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .sc_trip(sc), .cl_trip(cl),
      .gate_on(g0), .fault(f0), .warn(w0));

   ocp_pulse_guard #(.N_LEGS(LEGS), .SYNC_STAGES(2), .MAX_ON_CYC(MAXC),
      .MIN_ON_CYC(MINC), .STRETCH_SHORT(1'b1)) uut_st (
      .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .sc_trip(sc), .cl_trip(cl),
      .gate_on(g1), .fault(f1), .warn(w1));

   // reference model: k=0 suppress variant, k=1 stretch variant
   bit p0 [2][NCH];
   bit p1 [2][NCH];
   int run [2][NCH];
   int hold [2][NCH];
   bit scl [2][NCH];
   bit cll [2][NCH];
   bit [NCH-1:0] eg [2];
   bit ef [2];
   bit ew [2];

   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
               p0[k][c] = 1; p1[k][c] = 1; run[k][c] = 0; hold[k][c] = 0;
               scl[k][c] = 0; cll[k][c] = 0;
            end
            eg[k] = '0; ef[k] = 0; ew[k] = 0;
         end else begin
            bit anysc, anycl;
            anysc = 0; anycl = 0;
            for (int c = 0; c < NCH; c++) begin
               bit on, rise, scn, cln, g, too_long;
               int r;
               on   = !p1[k][c];
               rise = on && (run[k][c] == 0);
               r    = on ? run[k][c] + 1 : 0;
               scn  = sc[c] || (scl[k][c] && !rise);
               cln  = cl[c] || (cll[k][c] && !rise);
               too_long = on && (r > MAXC);
               if (c == 2 * LEGS) g = on;
               else if (c >= LEGS) g = on && !too_long && !scn;
               else if (k == 0) g = on && (r >= MINC) && !too_long && !scn;
               else g = (on || hold[k][c] > 0) && !too_long && !scn;
               if (rise) hold[k][c] = MINC - 1;
               else if (hold[k][c] > 0) hold[k][c] = hold[k][c] - 1;
               run[k][c] = r;
               scl[k][c] = scn;
               cll[k][c] = cln;
               eg[k][c]  = g;
               anysc = anysc || scn;
               anycl = anycl || cln;
               p1[k][c] = p0[k][c];
               p0[k][c] = cmd_n[c];
            end
            ef[k] = anysc;
            ew[k] = anycl;
         end
      end
   end

   task automatic check(input string what, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      check("gate sup", g0, eg[0]);
      check("gate str", g1, eg[1]);
      check("fault sup", {6'd0, f0}, {6'd0, ef[0]});
      check("fault str", {6'd0, f1}, {6'd0, ef[1]});
      check("warn sup", {6'd0, w0}, {6'd0, ew[0]});
      check("warn str", {6'd0, w1}, {6'd0, ew[1]});
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int ch, input int len, input int gap);
      cmd_n[ch] = 1'b0; cyc(len);
      cmd_n[ch] = 1'b1; cyc(gap);
   endtask

   initial begin
      #4000000;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R10: reset state and idle afterwards
      cur_req = "R10";
      cyc(4);
      rst_n = 1'b1;
      cyc(5);
      // R9: latency and channel order, lower and upper legs
      cur_req = "R9";
      pulse(3, 6, 5);
      pulse(0, 8, 5);
      // R4: brake follows command beyond the width limit
      cur_req = "R4";
      pulse(6, 20, 5);
      // R7/R8: short and boundary upper pulses
      cur_req = "R7";
      pulse(1, 2, 6);
      pulse(1, 3, 6);
      cur_req = "R8";
      pulse(1, 1, 6);
      pulse(1, 5, 6);
      // R6: truncation of long pulses on lower and upper legs
      cur_req = "R6";
      pulse(4, 20, 5);
      pulse(0, 20, 5);
      // R1/R2: trip on a running lower switch, neighbours unaffected
      cur_req = "R1";
      cmd_n[3] = 0; cmd_n[4] = 0; cyc(5);
      sc[3] = 1; cyc(1); sc[3] = 0; cyc(4);
      cur_req = "R2";
      sc[6] = 1; cmd_n[6] = 0; cyc(1); sc[6] = 0; cyc(4);
      // R3: next pulse clears; same-clock flag keeps trip set
      cur_req = "R3";
      cmd_n[3] = 1; cmd_n[4] = 1; cmd_n[6] = 1; cyc(4);
      cmd_n[3] = 0; sc[3] = 1; cyc(3); sc[3] = 0; cyc(4);
      cmd_n[3] = 1; cyc(3);
      cmd_n[3] = 0; cmd_n[6] = 0; cyc(6);
      cmd_n[3] = 1; cmd_n[6] = 1; cyc(4);
      // R5: warning set and cleared by next pulse
      cur_req = "R5";
      cmd_n[5] = 0; cyc(3); cl[5] = 1; cyc(1); cl[5] = 0; cyc(4);
      cmd_n[5] = 1; cyc(3); cmd_n[5] = 0; cyc(5); cmd_n[5] = 1; cyc(3);
      // mixed random traffic
      cur_req = "R9";
      for (int i = 0; i < 3000; i++) begin
         for (int c = 0; c < NCH; c++) begin
            if ($urandom_range(0, 9) == 0) cmd_n[c] = ~cmd_n[c];
            sc[c] = ($urandom_range(0, 60) == 0);
            cl[c] = ($urandom_range(0, 40) == 0);
         end
         cyc(1);
      end
      sc = '0; cl = '0; cmd_n = '1;
      cyc(10);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule